// File: doc/BRIEF.md
# Clock Source Selection and Divider Controller

This block decides which clock source drives a small microcontroller and how far that source is divided. Every clock in the tree is represented by a single-cycle enable pulse derived from one fast reference clock. The reference clock is nominally 480 MHz, set by the parameter `REF_KHZ`. The block chooses among three sources. The first is the primary oscillator path, which runs either directly (bypass) or through a 96 MHz PLL followed by a fixed divide-by-two to a 48 MHz node. The second is a low-power secondary oscillator (32.768 kHz). The third is an internal oscillator, postscaled down from 8 MHz or taken from a separate 31.25 kHz source.

The PLL is modelled as a lock timer. The timer starts counting when the PLL is enabled and runs for a programmable number of reference cycles. Until it expires, the system keeps running on the bypass path. When software selects a low-power source, the primary oscillator and the PLL are powered down, unless the reference clock output still needs them. All source and divider changes are held until the current output period ends. As a result, no shortened enable pulse is ever produced. A flag shows whether the active configuration can clock USB.

Top module: `clock_source_ctrl`

## Requirements
- R1: `srcSel` selects the source: 00 is primary, 01 is secondary and 11 is internal. `activeSrc` reports the same codes. Code 10 is treated as primary and sets `cfgError`. `cfgError` stays set until reset.
- R2: With the internal source, `postCode` sets the output period in reference cycles to REF_KHZ / f. For code 7 down to code 1, f is 8000 kHz shifted right by (7 - code). Code 0 gives the 31.25 kHz source, with a period of REF_KHZ*4/125. By default this gives 60, 120, 240, 480, 960, 1920, 3840 and 15360.
- R3: With the secondary source, the period is REF_KHZ*1000/32768, which is 14648 by default.
- R4: On the primary bypass path, the period is REF_KHZ / (4000 * P) multiplied by the CPU divider. P is the prescale ratio for `preCode` 0..7: 12, 10, 6, 5, 4, 3, 2, 1. In other words, the oscillator runs at P times 4 MHz.
- R5: `cpuCode` 0..3 multiplies the primary-path period by 1, 2, 3 or 6. It has no effect on the secondary or internal source.
- R6: With `pllEnable` high and the PLL not powered down, `pllLocked` rises after `lockTime`+1 consecutive clock edges. Until then, the period stays on bypass. After lock, the primary path runs at the 48 MHz node: a period of REF_KHZ/48000 times the CPU divider, with `pllPath` high.
- R7: Clearing `pllEnable` drops `pllLocked` at the next edge. It also restarts the lock count and returns the primary path to bypass.
- R8: While `srcSel` is 01 or 11 and `refOutReq` is low, `oscPowerDown` is high one edge later, and the PLL is forced unlocked. While `refOutReq` is high, neither happens.
- R9: `usbUsable` is high only while the active source is primary and running from the locked PLL path.
- R10: A new source or ratio takes effect only when the current enable period completes. The period in progress keeps its old length.
- R11: `sysClkEn` is a single-cycle pulse that repeats every `activePeriod` reference cycles.
- R12: During reset, `sysClkEn`, `pllLocked`, `pllPath`, `oscPowerDown`, `usbUsable` and `cfgError` are 0, and `activeSrc` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSel | input | 2 | Source select code |
| postCode | input | 3 | Internal oscillator postscaler code |
| preCode | input | 3 | PLL input prescaler code |
| cpuCode | input | 2 | CPU divider code |
| pllEnable | input | 1 | PLL enable |
| refOutReq | input | 1 | Reference clock output needs the primary oscillator |
| lockTime | input | LOCK_W | PLL lock interval in cycles, minus one |
| sysClkEn | output | 1 | System clock enable pulse |
| activeSrc | output | 2 | Source currently driving the system clock |
| activePeriod | output | PER_W | Period of sysClkEn in reference cycles |
| pllPath | output | 1 | Active period comes from the PLL node |
| pllLocked | output | 1 | PLL lock flag |
| oscPowerDown | output | 1 | Primary oscillator and PLL power-down request |
| usbUsable | output | 1 | Active configuration can clock USB |
| cfgError | output | 1 | Sticky flag for the unused select code |

## Verification
The status outputs `pllLocked`, `oscPowerDown` and `cfgError` are due one edge after the inputs are sampled. The bench therefore samples them at the following falling edge, and for the lock timer it counts exactly `lockTime` and `lockTime`+1 edges. Period results pass through two stages: the control stage registers the selection, and the datapath applies it at its next terminal count. For this reason the bench waits two edges and then a full pulse before it measures the interval between pulses and reads `activePeriod` and `activeSrc`. The glitch-free check changes the divider partway through a measured period and expects that period to keep its old length.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  typedef enum logic [1:0] {
    SRC_PRIMARY   = 2'b00,
    SRC_SECONDARY = 2'b01,
    SRC_INTERNAL  = 2'b11
  } src_e;

  // Strobes from control to datapath, registered in control.
  typedef struct packed {
    src_e       src;
    logic       usePll;
    logic [2:0] postCode;
    logic [2:0] preCode;
    logic [1:0] cpuCode;
  } path_sel_t;

endpackage

// File: rtl/clk_src_control.sv
module clk_src_control
  import clk_src_pkg::*;
#(
  parameter int unsigned LOCK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        srcSel,
  input  logic [2:0]        postCode,
  input  logic [2:0]        preCode,
  input  logic [1:0]        cpuCode,
  input  logic              pllEnable,
  input  logic              refOutReq,
  input  logic [LOCK_W-1:0] lockTime,
  output path_sel_t         sel,
  output logic              pllLocked,
  output logic              oscPowerDown,
  output logic              cfgError
);

  logic              lowPowerSrc;
  logic              pdNext;
  logic              pllRun;
  logic              lockedNext;
  logic [LOCK_W-1:0] lockCnt;
  src_e              srcMapped;

  assign lowPowerSrc = (srcSel == 2'b01) || (srcSel == 2'b11);
  assign pdNext      = lowPowerSrc && !refOutReq;
  assign pllRun      = pllEnable && !pdNext;
  assign lockedNext  = pllRun && (pllLocked || (lockCnt == lockTime));
  assign srcMapped   = (srcSel == 2'b10) ? SRC_PRIMARY : src_e'(srcSel);

  // Lock timer: counts while the PLL runs, cleared whenever it stops.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt   <= '0;
      pllLocked <= 1'b0;
    end else if (!pllRun) begin
      lockCnt   <= '0;
      pllLocked <= 1'b0;
    end else begin
      pllLocked <= lockedNext;
      if (!lockedNext) lockCnt <= lockCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscPowerDown <= 1'b0;
      cfgError     <= 1'b0;
      sel          <= '{src: SRC_PRIMARY, usePll: 1'b0, postCode: 3'd0,
                        preCode: 3'd0, cpuCode: 2'd0};
    end else begin
      oscPowerDown <= pdNext;
      if (srcSel == 2'b10) cfgError <= 1'b1;
      sel.src      <= srcMapped;
      sel.usePll   <= lockedNext;
      sel.postCode <= postCode;
      sel.preCode  <= preCode;
      sel.cpuCode  <= cpuCode;
    end
  end

  // R7: a cleared enable leaves the PLL unlocked after the next edge
  a_r7_lock_drops: assert property (@(posedge clk) disable iff (!rstN)
    !pllEnable |=> !pllLocked);

  // R8: a power-down request never coexists with a locked PLL
  a_r8_pd_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    oscPowerDown |-> !pllLocked);

  // R1: the error flag is sticky
  a_r1_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

endmodule

// File: rtl/clk_src_datapath.sv
module clk_src_datapath
  import clk_src_pkg::*;
#(
  parameter int unsigned REF_KHZ = 480000,
  parameter int unsigned PER_W   = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  path_sel_t        sel,
  output logic             sysClkEn,
  output logic [1:0]       activeSrc,
  output logic [PER_W-1:0] activePeriod,
  output logic             pllPath,
  output logic             usbUsable
);

  localparam int unsigned PLL_PER = REF_KHZ / 48000;
  localparam int unsigned SEC_PER = (REF_KHZ * 1000) / 32768;
  localparam int unsigned LF_PER  = (REF_KHZ * 4) / 125;

  int unsigned      bypassPer;
  int unsigned      intPer;
  int unsigned      cpuMult;
  int unsigned      fullPer;
  logic [PER_W-1:0] nextPeriod;
  logic [PER_W-1:0] cnt;
  logic             atTc;
  logic             nextPll;

  always_comb begin
    unique case (sel.preCode)
      3'd0: bypassPer = REF_KHZ / 48000;
      3'd1: bypassPer = REF_KHZ / 40000;
      3'd2: bypassPer = REF_KHZ / 24000;
      3'd3: bypassPer = REF_KHZ / 20000;
      3'd4: bypassPer = REF_KHZ / 16000;
      3'd5: bypassPer = REF_KHZ / 12000;
      3'd6: bypassPer = REF_KHZ / 8000;
      default: bypassPer = REF_KHZ / 4000;
    endcase
    unique case (sel.postCode)
      3'd0: intPer = LF_PER;
      3'd1: intPer = REF_KHZ / 125;
      3'd2: intPer = REF_KHZ / 250;
      3'd3: intPer = REF_KHZ / 500;
      3'd4: intPer = REF_KHZ / 1000;
      3'd5: intPer = REF_KHZ / 2000;
      3'd6: intPer = REF_KHZ / 4000;
      default: intPer = REF_KHZ / 8000;
    endcase
    unique case (sel.cpuCode)
      2'd0: cpuMult = 1;
      2'd1: cpuMult = 2;
      2'd2: cpuMult = 3;
      default: cpuMult = 6;
    endcase
    case (sel.src)
      SRC_SECONDARY: fullPer = SEC_PER;
      SRC_INTERNAL:  fullPer = intPer;
      default:       fullPer = (sel.usePll ? PLL_PER : bypassPer) * cpuMult;
    endcase
    nextPeriod = PER_W'(fullPer);
  end

  assign atTc    = (cnt == activePeriod - PER_W'(1));
  assign nextPll = sel.usePll && (sel.src == SRC_PRIMARY);

  // Selection is loaded only at the terminal count of the running period.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt          <= '0;
      activePeriod <= PER_W'(1);
      activeSrc    <= SRC_PRIMARY;
      pllPath      <= 1'b0;
      usbUsable    <= 1'b0;
      sysClkEn     <= 1'b0;
    end else if (atTc) begin
      cnt          <= '0;
      sysClkEn     <= 1'b1;
      activePeriod <= nextPeriod;
      activeSrc    <= sel.src;
      pllPath      <= nextPll;
      usbUsable    <= nextPll;
    end else begin
      cnt          <= cnt + PER_W'(1);
      sysClkEn     <= 1'b0;
    end
  end

  // R10: the period only changes together with an enable pulse
  a_r10_ratio_at_tc: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activePeriod) |-> sysClkEn);

  // R11: the phase counter stays inside the active period
  a_r11_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt < activePeriod);

  // R9: USB is only usable from the primary source
  a_r9_usb_primary: assert property (@(posedge clk) disable iff (!rstN)
    usbUsable |-> (activeSrc == SRC_PRIMARY));

endmodule

// File: rtl/clock_source_ctrl.sv
module clock_source_ctrl
  import clk_src_pkg::*;
#(
  parameter  int unsigned REF_KHZ = 480000,
  parameter  int unsigned LOCK_W  = 16,
  localparam int unsigned PER_W   = $clog2((REF_KHZ * 4) / 125 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        srcSel,
  input  logic [2:0]        postCode,
  input  logic [2:0]        preCode,
  input  logic [1:0]        cpuCode,
  input  logic              pllEnable,
  input  logic              refOutReq,
  input  logic [LOCK_W-1:0] lockTime,
  output logic              sysClkEn,
  output logic [1:0]        activeSrc,
  output logic [PER_W-1:0]  activePeriod,
  output logic              pllPath,
  output logic              pllLocked,
  output logic              oscPowerDown,
  output logic              usbUsable,
  output logic              cfgError
);

  path_sel_t sel;

  clk_src_control #(.LOCK_W(LOCK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .postCode(postCode),
    .preCode(preCode), .cpuCode(cpuCode), .pllEnable(pllEnable),
    .refOutReq(refOutReq), .lockTime(lockTime), .sel(sel),
    .pllLocked(pllLocked), .oscPowerDown(oscPowerDown), .cfgError(cfgError)
  );

  clk_src_datapath #(.REF_KHZ(REF_KHZ), .PER_W(PER_W)) u_dp (
    .clk(clk), .rstN(rstN), .sel(sel), .sysClkEn(sysClkEn),
    .activeSrc(activeSrc), .activePeriod(activePeriod),
    .pllPath(pllPath), .usbUsable(usbUsable)
  );

endmodule

// File: tb/tb_clock_source_ctrl.sv
module tb_clock_source_ctrl;

  localparam int unsigned REF   = 480000;
  localparam int unsigned LW    = 16;
  localparam int unsigned PW    = $clog2((REF * 4) / 125 + 1);
  localparam int          LOCKT = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    srcSel = 2'b00;
  logic [2:0]    postCode = 3'd0;
  logic [2:0]    preCode = 3'd0;
  logic [1:0]    cpuCode = 2'd0;
  logic          pllEnable = 1'b0;
  logic          refOutReq = 1'b0;
  logic [LW-1:0] lockTime = LW'(LOCKT);
  logic          sysClkEn, pllPath, pllLocked, oscPowerDown, usbUsable, cfgError;
  logic [1:0]    activeSrc;
  logic [PW-1:0] activePeriod;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  clock_source_ctrl #(.REF_KHZ(REF), .LOCK_W(LW)) dut (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .postCode(postCode),
    .preCode(preCode), .cpuCode(cpuCode), .pllEnable(pllEnable),
    .refOutReq(refOutReq), .lockTime(lockTime), .sysClkEn(sysClkEn),
    .activeSrc(activeSrc), .activePeriod(activePeriod), .pllPath(pllPath),
    .pllLocked(pllLocked), .oscPowerDown(oscPowerDown),
    .usbUsable(usbUsable), .cfgError(cfgError)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int preRatio(input int c);
    int t[8] = '{12, 10, 6, 5, 4, 3, 2, 1};
    return t[c];
  endfunction

  function automatic int cpuMult(input int c);
    int t[4] = '{1, 2, 3, 6};
    return t[c];
  endfunction

  function automatic int intPeriod(input int c);
    if (c == 0) return (REF * 4) / 125;
    return REF / (8000 >> (7 - c));
  endfunction

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sysClkEn);
  endtask

  // Wait for the selection to pass both stages, then measure one full period.
  task automatic settle(output int n);
    repeat (2) @(negedge clk);
    while (!sysClkEn) @(negedge clk);
    measure(n);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int n;
    int e;
    // R12: reset state
    repeat (3) @(negedge clk);
    check(sysClkEn == 0 && pllLocked == 0 && pllPath == 0, "R12 pulse/lock", int'(sysClkEn), 0);
    check(activeSrc == 2'b00 && cfgError == 0, "R12 src/err", int'(activeSrc), 0);
    check(oscPowerDown == 0 && usbUsable == 0, "R12 pd/usb", int'(oscPowerDown), 0);
    rstN = 1'b1;

    // R4 R5 R11: primary bypass sweep
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 4; c++) begin
        preCode = 3'(p);
        cpuCode = 2'(c);
        settle(n);
        e = REF / (4000 * preRatio(p)) * cpuMult(c);
        check(n == e, "R4 R11 bypass interval", n, e);
        check(int'(activePeriod) == e, "R5 bypass activePeriod", int'(activePeriod), e);
      end
    end

    // R2 R5 R8: internal sweep with a CPU divider that must not apply
    srcSel = 2'b11;
    cpuCode = 2'd3;
    for (int k = 7; k >= 0; k--) begin
      postCode = 3'(k);
      settle(n);
      e = intPeriod(k);
      check(n == e, "R2 R5 internal interval", n, e);
      check(activeSrc == 2'b11, "R1 internal activeSrc", int'(activeSrc), 3);
      check(oscPowerDown == 1, "R8 internal power down", int'(oscPowerDown), 1);
    end

    // R3: secondary oscillator
    srcSel = 2'b01;
    settle(n);
    e = (REF * 1000) / 32768;
    check(n == e, "R3 secondary interval", n, e);
    check(activeSrc == 2'b01, "R3 secondary activeSrc", int'(activeSrc), 1);

    // R1: unused code maps to primary and sets sticky error
    srcSel = 2'b10;
    preCode = 3'd2;
    cpuCode = 2'd0;
    settle(n);
    check(n == 20, "R1 code10 interval", n, 20);
    check(activeSrc == 2'b00, "R1 code10 activeSrc", int'(activeSrc), 0);
    check(cfgError == 1, "R1 cfgError set", int'(cfgError), 1);
    srcSel = 2'b00;
    repeat (3) @(negedge clk);
    check(cfgError == 1, "R1 cfgError sticky", int'(cfgError), 1);
    check(oscPowerDown == 0, "R8 primary no power down", int'(oscPowerDown), 0);

    // R6: lock timer
    pllEnable = 1'b1;
    repeat (LOCKT) @(negedge clk);
    check(pllLocked == 0, "R6 not yet locked", int'(pllLocked), 0);
    check(usbUsable == 0, "R9 no usb before lock", int'(usbUsable), 0);
    @(negedge clk);
    check(pllLocked == 1, "R6 locked", int'(pllLocked), 1);
    settle(n);
    check(n == 10, "R6 pll interval", n, 10);
    check(pllPath == 1 && usbUsable == 1, "R9 usb on pll", int'(usbUsable), 1);
    cpuCode = 2'd1;
    settle(n);
    check(n == 20, "R5 R6 pll with div2", n, 20);

    // R7: clear enable
    pllEnable = 1'b0;
    @(negedge clk);
    check(pllLocked == 0, "R7 lock dropped", int'(pllLocked), 0);
    settle(n);
    check(n == 40, "R7 back to bypass", n, 40);
    check(usbUsable == 0 && pllPath == 0, "R9 usb off on bypass", int'(usbUsable), 0);
    pllEnable = 1'b1;
    repeat (LOCKT) @(negedge clk);
    check(pllLocked == 0, "R7 count restarted", int'(pllLocked), 0);
    @(negedge clk);
    check(pllLocked == 1, "R7 relocked", int'(pllLocked), 1);

    // R8: reference output keeps PLL alive on a low-power source
    srcSel = 2'b11;
    postCode = 3'd7;
    refOutReq = 1'b1;
    @(negedge clk);
    check(oscPowerDown == 0, "R8 refOut holds osc", int'(oscPowerDown), 0);
    check(pllLocked == 1, "R8 refOut holds pll", int'(pllLocked), 1);
    settle(n);
    check(usbUsable == 0, "R9 no usb on internal", int'(usbUsable), 0);
    refOutReq = 1'b0;
    @(negedge clk);
    check(oscPowerDown == 1, "R8 power down", int'(oscPowerDown), 1);
    check(pllLocked == 0, "R8 pll forced off", int'(pllLocked), 0);

    // R10: change mid-period keeps the running period
    srcSel = 2'b00;
    pllEnable = 1'b0;
    preCode = 3'd0;
    cpuCode = 2'd3;
    settle(n);
    check(n == 60, "R10 start interval", n, 60);
    n = 0;
    repeat (5) begin
      @(negedge clk);
      n++;
    end
    cpuCode = 2'd0;
    do begin
      @(negedge clk);
      n++;
    end while (!sysClkEn);
    check(n == 60, "R10 running period kept", n, 60);
    measure(n);
    check(n == 10, "R10 new period after tc", n, 10);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule